// File: doc/BRIEF.md
# PCI Configuration Header Register File

This block holds the 256-byte configuration header of a PCI function that exposes a USB host controller through a small I/O window. Software reaches it through a write port and a read port. Each port takes a starting byte address and an access length of one to four bytes. Bytes are packed little-endian into a 32-bit data word. An access that runs past the last byte wraps around to byte 0x00. Reads are combinational from the stored bytes. A write takes effect at the rising clock edge.

Reset loads a fixed image: identity words, class code, command and status defaults, the I/O base register, the interrupt line and pin, and two bytes in the device-specific area. Every other byte resets to zero. Writes pass through a filter that works at two levels. A write whose starting address falls in one of two reserved windows is dropped as a whole. Within an accepted write, three protected bytes are skipped.

When a write changes either of the two low bytes of the I/O base register, the block raises a one-cycle pulse. Alongside the pulse it presents the new 32-byte-aligned base, so that the decoder of the I/O window can move.

Top module: `cfg_space_regfile`

## Requirements
- R1: After reset, every byte reads zero except the following. Bytes 0x04..0x07 hold 0x05, 0x00, 0x80, 0x02. Bytes 0x08..0x0B hold 0x01, 0x00, 0x03, 0x0C. Byte 0x0D holds 0x20. Byte 0x3C holds parameter IRQ_LINE and byte 0x3D holds 0x04. Byte 0x6A holds 0x01 and byte 0xC1 holds 0x20. The byte groups of R2 and R3 are also excepted.
- R2: After reset, bytes 0x00..0x01 hold parameter VENDOR_ID and bytes 0x02..0x03 hold parameter DEVICE_ID, each low byte first.
- R3: After reset, byte 0x20 holds (IO_BASE[7:0] & 0xE0) | 0x01 and byte 0x21 holds IO_BASE[15:8]. Bytes 0x22..0x23 hold zero.
- R4: A read of length L (1..4) at address A returns byte A+i in bits 8i+7:8i for each i below L. All bits above 8L-1 are zero. A write of length L stores bits 8i+7:8i into byte A+i.
- R5: A read with length 0 or 5..7 returns 0xFFFFFFFF.
- R6: A write whose starting address lies in 0x10..0x1F or in 0x24..0x33 changes no byte, including bytes beyond those windows. A write starting at 0x0F or at 0x34 is accepted.
- R7: Bytes 0x05, 0x06 and 0x3D are never changed by a write. The other bytes covered by the same write are updated.
- R8: A write with length 0 or 5..7 changes no byte.
- R9: A read or write that runs past byte 0xFF continues at byte 0x00 (addresses wrap modulo 256).
- R10: bar_chg is high for exactly the cycle after a write edge that changed the value of byte 0x20 or byte 0x21. Rewriting the same values, or writing other bytes, gives no pulse. bar_base always equals {byte 0x21, byte 0x20 & 0xE0}.
- R11: When a read and a write fall in the same cycle, the read returns the contents from before that write. The written data is visible from the cycle after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request for this cycle |
| wr_addr | input | 8 | Starting byte address of the write |
| wr_len | input | 3 | Write length in bytes |
| wr_data | input | 32 | Write data, little-endian |
| rd_addr | input | 8 | Starting byte address of the read |
| rd_len | input | 3 | Read length in bytes |
| rd_data | output | 32 | Read data, little-endian, combinational |
| bar_chg | output | 1 | One-cycle pulse after the I/O base changed |
| bar_base | output | 16 | Current 32-byte-aligned I/O base |

## Verification
A read and a write can target the same bytes in one cycle. The base-change detection can also coincide with a read of the base register. The bench drives both ports before a clock edge and samples rd_data just before that edge, where it expects the old bytes. It samples again after the edge, where it expects the new bytes together with the bar_chg pulse and the moved bar_base. One such case writes the high base byte while reading the whole base word. This shows that detection compares against the pre-write byte, and that the read mux never shows the update early.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;

  localparam int ADDR_W   = 8;
  localparam int LEN_W    = 3;
  localparam int MAX_LEN  = 4;
  localparam logic [7:0] BAR_LO_ADDR = 8'h20;
  localparam logic [7:0] BAR_HI_ADDR = 8'h21;
  localparam logic [7:0] BAR_ALIGN_MASK = 8'hE0;

  // start address inside a window where whole writes are discarded
  function automatic logic in_drop_window(input logic [7:0] a);
    return ((a >= 8'h10) && (a <= 8'h1F)) || ((a >= 8'h24) && (a <= 8'h33));
  endfunction

  // bytes that no write may modify
  function automatic logic is_locked_byte(input logic [7:0] a);
    return (a == 8'h05) || (a == 8'h06) || (a == 8'h3D);
  endfunction

  function automatic logic len_valid(input logic [LEN_W-1:0] len);
    return (len != '0) && (int'(len) <= MAX_LEN);
  endfunction

  function automatic logic [15:0] bar_base_of(input logic [7:0] lo, input logic [7:0] hi);
    return {hi, lo & BAR_ALIGN_MASK};
  endfunction

  // reset image, one byte at a time
  function automatic logic [7:0] reset_byte(
    input logic [7:0]  a,
    input logic [15:0] vid,
    input logic [15:0] did,
    input logic [15:0] iob,
    input logic [7:0]  irq
  );
    case (a)
      8'h00: return vid[7:0];
      8'h01: return vid[15:8];
      8'h02: return did[7:0];
      8'h03: return did[15:8];
      8'h04: return 8'h05;
      8'h06: return 8'h80;
      8'h07: return 8'h02;
      8'h08: return 8'h01;
      8'h0A: return 8'h03;
      8'h0B: return 8'h0C;
      8'h0D: return 8'h20;
      8'h20: return (iob[7:0] & BAR_ALIGN_MASK) | 8'h01;
      8'h21: return iob[15:8];
      8'h3C: return irq;
      8'h3D: return 8'h04;
      8'h6A: return 8'h01;
      8'hC1: return 8'h20;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cfg_wr_lanes.sv
module cfg_wr_lanes
  import cfg_space_pkg::*;
#(
  parameter int LANES = MAX_LEN
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [LEN_W-1:0]           wr_len,
  input  logic [8*LANES-1:0]         wr_data,
  output logic [LANES-1:0]           lane_we,
  output logic [LANES-1:0][ADDR_W-1:0] lane_addr,
  output logic [LANES-1:0][7:0]      lane_data
);

  logic accept;
  assign accept = wr_en && len_valid(wr_len) && !in_drop_window(wr_addr);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic covered;
    assign lane_addr[i] = wr_addr + ADDR_W'(i);
    assign lane_data[i] = wr_data[8*i +: 8];
    assign covered      = (i < int'(wr_len));
    assign lane_we[i]   = accept && covered && !is_locked_byte(lane_addr[i]);
  end

  // R6: a write starting inside a reserved window enables no lane
  p_drop_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_drop_window(wr_addr)) |-> (lane_we == '0));

  // R8: an out-of-range length enables no lane
  p_bad_wr_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ((wr_len == '0) || (int'(wr_len) > LANES))) |-> (lane_we == '0));

endmodule

// File: rtl/cfg_rd_assemble.sv
module cfg_rd_assemble
  import cfg_space_pkg::*;
#(
  parameter int LANES = MAX_LEN
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LEN_W-1:0]      rd_len,
  input  logic [LANES-1:0][7:0] lane_byte,
  output logic [8*LANES-1:0]    rd_data
);

  logic [8*LANES-1:0] packed_word;

  always_comb begin
    packed_word = '0;
    for (int i = 0; i < LANES; i++) begin
      if (i < int'(rd_len)) packed_word[8*i +: 8] = lane_byte[i];
    end
  end

  assign rd_data = len_valid(rd_len) ? packed_word : '1;

  // R5: invalid read length returns all ones
  p_bad_rd_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_len == '0) || (int'(rd_len) > LANES)) |-> (rd_data == '1));

  // R4: a one-byte read never carries data above the low byte
  p_rd_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_len == LEN_W'(1)) |-> (rd_data[8*LANES-1:8] == '0));

endmodule

// File: rtl/cfg_bar_watch.sv
module cfg_bar_watch
  import cfg_space_pkg::*;
#(
  parameter int LANES = MAX_LEN
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [LANES-1:0]             lane_we,
  input  logic [LANES-1:0][ADDR_W-1:0] lane_addr,
  input  logic [LANES-1:0][7:0]        lane_data,
  input  logic [7:0]                   cur_lo,
  input  logic [7:0]                   cur_hi,
  output logic                         bar_chg,
  output logic [15:0]                  bar_base
);

  logic [LANES-1:0] lane_moves;
  logic             base_moves;

  for (genvar i = 0; i < LANES; i++) begin : g_cmp
    assign lane_moves[i] = lane_we[i] &&
      (((lane_addr[i] == BAR_LO_ADDR) && (lane_data[i] != cur_lo)) ||
       ((lane_addr[i] == BAR_HI_ADDR) && (lane_data[i] != cur_hi)));
  end

  assign base_moves = |lane_moves;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bar_chg <= 1'b0;
    else        bar_chg <= base_moves;
  end

  assign bar_base = bar_base_of(cur_lo, cur_hi);

  // R10: a pulse follows a cycle with an accepted write
  p_pulse_needs_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bar_chg |-> $past(|lane_we));

  // R10: the pulse always accompanies a change of the presented raw base bytes
  p_pulse_means_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bar_chg |-> (({cur_hi, cur_lo} != $past({cur_hi, cur_lo}))));

  // R10: without a write the base bytes hold still
  p_base_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(|lane_we) |=> $stable(bar_base));

endmodule

// File: rtl/cfg_space_regfile.sv
module cfg_space_regfile
  import cfg_space_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'hA5C3,
  parameter logic [15:0] DEVICE_ID = 16'h7020,
  parameter logic [15:0] IO_BASE   = 16'hC05F,
  parameter logic [7:0]  IRQ_LINE  = 8'h0B
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_addr,
  input  logic [2:0]  wr_len,
  input  logic [31:0] wr_data,
  input  logic [7:0]  rd_addr,
  input  logic [2:0]  rd_len,
  output logic [31:0] rd_data,
  output logic        bar_chg,
  output logic [15:0] bar_base
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int LANES = MAX_LEN;

  logic [7:0] mem_q [DEPTH];

  logic [LANES-1:0]             lane_we;
  logic [LANES-1:0][ADDR_W-1:0] lane_addr;
  logic [LANES-1:0][7:0]        lane_data;
  logic [LANES-1:0][7:0]        rd_byte;

  cfg_wr_lanes #(.LANES(LANES)) u_wr_lanes (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_len    (wr_len),
    .wr_data   (wr_data),
    .lane_we   (lane_we),
    .lane_addr (lane_addr),
    .lane_data (lane_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++)
        mem_q[k] <= reset_byte(8'(k), VENDOR_ID, DEVICE_ID, IO_BASE, IRQ_LINE);
    end else begin
      for (int i = 0; i < LANES; i++)
        if (lane_we[i]) mem_q[lane_addr[i]] <= lane_data[i];
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_rd
    assign rd_byte[i] = mem_q[rd_addr + ADDR_W'(i)];
  end

  cfg_rd_assemble #(.LANES(LANES)) u_rd_assemble (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_len    (rd_len),
    .lane_byte (rd_byte),
    .rd_data   (rd_data)
  );

  cfg_bar_watch #(.LANES(LANES)) u_bar_watch (
    .clk       (clk),
    .rst_n     (rst_n),
    .lane_we   (lane_we),
    .lane_addr (lane_addr),
    .lane_data (lane_data),
    .cur_lo    (mem_q[BAR_LO_ADDR]),
    .cur_hi    (mem_q[BAR_HI_ADDR]),
    .bar_chg   (bar_chg),
    .bar_base  (bar_base)
  );

  // R7: protected bytes keep their value across any write
  p_locked_bytes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ($stable(mem_q[8'h05]) && $stable(mem_q[8'h06]) && $stable(mem_q[8'h3D])));

  // R11: a byte only changes at an edge that carried a write
  p_change_needs_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem_q[8'h40]));

endmodule

// File: tb/cfg_space_regfile_bench.sv
module cfg_space_regfile_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [2:0]  wr_len = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [2:0]  rd_len = '0;
  logic [31:0] rd_data;
  logic        bar_chg;
  logic [15:0] bar_base;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cfg_space_regfile u_cfg_space_regfile (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_len(wr_len), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_len(rd_len), .rd_data(rd_data),
    .bar_chg(bar_chg), .bar_base(bar_base)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  waddr;
    logic [2:0]  wlen;
    logic [31:0] wdata;
    logic [7:0]  raddr;
    logic [2:0]  rlen;
    logic [31:0] rexp;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 27;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 8'h00, 3'd0, 32'h0,        8'h00, 3'd4, 32'h7020A5C3, 8'd2},  // R2 ids
    '{1'b0, 8'h00, 3'd0, 32'h0,        8'h04, 3'd4, 32'h02800005, 8'd1},  // R1 cmd/status
    '{1'b0, 8'h00, 3'd0, 32'h0,        8'h08, 3'd4, 32'h0C030001, 8'd1},  // R1 rev/class
    '{1'b0, 8'h00, 3'd0, 32'h0,        8'h0C, 3'd4, 32'h00002000, 8'd1},  // R1 latency
    '{1'b0, 8'h00, 3'd0, 32'h0,        8'h20, 3'd4, 32'h0000C041, 8'd3},  // R3 base reg
    '{1'b0, 8'h00, 3'd0, 32'h0,        8'h3C, 3'd2, 32'h0000040B, 8'd1},  // R1 irq line/pin
    '{1'b0, 8'h00, 3'd0, 32'h0,        8'h6A, 3'd1, 32'h00000001, 8'd1},  // R1
    '{1'b0, 8'h00, 3'd0, 32'h0,        8'hC1, 3'd1, 32'h00000020, 8'd1},  // R1
    '{1'b0, 8'h00, 3'd0, 32'h0,        8'h3D, 3'd3, 32'h00000004, 8'd4},  // R4 3-byte read
    '{1'b1, 8'h40, 3'd4, 32'h11223344, 8'h40, 3'd4, 32'h11223344, 8'd4},  // R4 dword
    '{1'b0, 8'h00, 3'd0, 32'h0,        8'h41, 3'd2, 32'h00002233, 8'd4},  // R4 unaligned word
    '{1'b0, 8'h00, 3'd0, 32'h0,        8'h43, 3'd1, 32'h00000011, 8'd4},  // R4 byte
    '{1'b1, 8'h50, 3'd2, 32'hDEADBEEF, 8'h50, 3'd4, 32'h0000BEEF, 8'd4},  // R4 word write
    '{1'b1, 8'h04, 3'd4, 32'hFFFFFFFF, 8'h04, 3'd4, 32'hFF8000FF, 8'd7},  // R7 05/06
    '{1'b1, 8'h3C, 3'd2, 32'h00005555, 8'h3C, 3'd2, 32'h00000455, 8'd7},  // R7 3D
    '{1'b1, 8'h10, 3'd4, 32'hAAAAAAAA, 8'h10, 3'd4, 32'h00000000, 8'd6},  // R6
    '{1'b1, 8'h1E, 3'd4, 32'h12345678, 8'h20, 3'd2, 32'h0000C041, 8'd6},  // R6 spill dropped
    '{1'b1, 8'h24, 3'd1, 32'h00000099, 8'h24, 3'd1, 32'h00000000, 8'd6},  // R6
    '{1'b1, 8'h33, 3'd4, 32'h99887766, 8'h34, 3'd2, 32'h00000000, 8'd6},  // R6 spill dropped
    '{1'b1, 8'h34, 3'd1, 32'h0000007E, 8'h34, 3'd1, 32'h0000007E, 8'd6},  // R6 edge accepted
    '{1'b1, 8'h0F, 3'd2, 32'h0000CD9A, 8'h0F, 3'd2, 32'h0000CD9A, 8'd6},  // R6 edge accepted
    '{1'b1, 8'hFE, 3'd4, 32'h44332211, 8'hFE, 3'd4, 32'h44332211, 8'd9},  // R9 wrap
    '{1'b0, 8'h00, 3'd0, 32'h0,        8'h00, 3'd2, 32'h00004433, 8'd9},  // R9 wrapped bytes
    '{1'b1, 8'h60, 3'd0, 32'hFFFFFFFF, 8'h60, 3'd1, 32'h00000000, 8'd8},  // R8 len 0
    '{1'b1, 8'h60, 3'd5, 32'hFFFFFFFF, 8'h60, 3'd4, 32'h00000000, 8'd8},  // R8 len 5
    '{1'b0, 8'h00, 3'd0, 32'h0,        8'h00, 3'd0, 32'hFFFFFFFF, 8'd5},  // R5 len 0
    '{1'b0, 8'h00, 3'd0, 32'h0,        8'h00, 3'd7, 32'hFFFFFFFF, 8'd5}   // R5 len 7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd_now(input logic [7:0] a, input logic [2:0] l);
    rd_addr = a;
    rd_len  = l;
    #1;
  endtask

  task automatic write_op(input logic [7:0] a, input logic [2:0] l, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_len = l; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R10 reset pulse", {31'b0, bar_chg}, 32'h0);
    check("R3 reset base", {16'b0, bar_base}, 32'h0000C040);
    rd_now(8'h80, 3'd4);
    check("R1 zero byte", rd_data, 32'h0);

    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      wr_en = VEC[v].wr; wr_addr = VEC[v].waddr; wr_len = VEC[v].wlen; wr_data = VEC[v].wdata;
      @(negedge clk);
      wr_en = 1'b0;
      rd_now(VEC[v].raddr, VEC[v].rlen);
      check($sformatf("R%0d vector %0d", VEC[v].req, v), rd_data, VEC[v].rexp);
    end

    // R10: changing write pulses once and moves the base
    write_op(8'h20, 3'd2, 32'h0000D001);
    check("R10 pulse", {31'b0, bar_chg}, 32'h1);
    check("R10 new base", {16'b0, bar_base}, 32'h0000D000);
    @(negedge clk); #1;
    check("R10 pulse width", {31'b0, bar_chg}, 32'h0);
    // R10: same value, no pulse
    write_op(8'h20, 3'd2, 32'h0000D001);
    check("R10 same value", {31'b0, bar_chg}, 32'h0);
    // R10: neighbouring byte, no pulse
    write_op(8'h22, 3'd1, 32'h000000AB);
    check("R10 other byte", {31'b0, bar_chg}, 32'h0);

    // R11: read and write of the same byte in one cycle
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'h70; wr_len = 3'd1; wr_data = 32'h5A;
    rd_now(8'h70, 3'd1);
    check("R11 old data", rd_data, 32'h0);
    @(negedge clk);
    wr_en = 1'b0; #1;
    check("R11 new data", rd_data, 32'h5A);

    // R11 with R10: base high byte written while base word is read
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'h21; wr_len = 3'd1; wr_data = 32'hE0;
    rd_now(8'h20, 3'd2);
    check("R11 base before", rd_data, 32'h0000D001);
    @(negedge clk);
    wr_en = 1'b0; #1;
    check("R11 base after", rd_data, 32'h0000E001);
    check("R10 coincident pulse", {31'b0, bar_chg}, 32'h1);
    check("R10 coincident base", {16'b0, bar_base}, 32'h0000E000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule